// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block controls an eight-pin parallel I/O port. Each pin is general-purpose I/O by default. A pin can also be handed to one of two timer channels. Software reaches four 8-bit control registers over a small register bus that has an address, a write strobe, write data and read data: the output latch, the pullup enables, the slew enables and the direction. For every pin the block computes a drive value, an output enable, a pullup request and a slew request for the pad. It also brings the pad level back through a two-flop synchronizer. The synchronized level feeds both the read path and the timers' capture inputs.

Each pin has a timer ownership flag and a mode flag. The mode flag is 1 for output compare and 0 for input capture. While a timer owns a pin, that pin's direction bit has no say over the output enable. In output compare mode the timer's value drives the pin and the slew bit reaches the pad. In input capture mode the pin floats, and the pullup bit is honoured only while the direction bit is 0. The register bus is a control path and has no back-pressure: a write takes effect at the clock edge where the write strobe is high, and read data is registered, so it appears one cycle after the address.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, all four registers read 0, and every pin has output enable, pullup and slew at 0, so no pin is driven.
- R2: A write at offset 1 (pullup), offset 2 (slew) or offset 3 (direction) stores all eight bits. A read of the same offset returns them.
- R3: A write at offset 0 latches all eight data bits whatever the direction. A read at offset 0 returns the latch for bits whose direction is 1 (output) and the synchronized pin level for bits whose direction is 0 (input). bus_rdata reflects the address presented in the previous cycle.
- R4: A change on pin_in reaches tmr_cap and the read path after two clock edges.
- R5: For a pin not owned by a timer, pin_oe equals its direction bit. pin_out equals the latch bit when driven and is 0 when not driven.
- R6: For a pin not owned by a timer, pin_pu equals its pullup bit (1 = enabled) when the direction is 0, and is 0 when the direction is 1.
- R7: For a pin not owned by a timer, pin_slew equals its slew bit when the pin is driven, and is 0 otherwise.
- R8: A timer-owned pin in output compare mode (tmr_oc=1) has pin_oe=1, pin_out=tmr_val, pin_slew equal to its slew bit and pin_pu=0, regardless of its direction bit.
- R9: A timer-owned pin in input capture mode (tmr_oc=0) has pin_oe=0, pin_out=0 and pin_slew=0. Its pin_pu equals its pullup bit AND NOT its direction bit.
- R10: Offsets 4 to 7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pin_in | input | 8 | Sampled pad levels (asynchronous) |
| pin_out | output | 8 | Drive value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Pullup request per pin |
| pin_slew | output | 8 | Slew-control request per pin |
| tmr_own | input | 8 | Pin owned by a timer channel |
| tmr_oc | input | 8 | Owning timer mode: 1 output compare, 0 input capture |
| tmr_val | input | 8 | Timer output compare value |
| tmr_cap | output | 8 | Synchronized pin level for timer capture |

## Verification
The bench targets several wrong behaviours.

- **Direction bit under timer ownership.** The bench sets direction bits to 1 on pins owned by input capture. A design that still let direction drive the output enable would drive those pins and fail R9. The same setup exposes a missing direction gate on the pullup, which would request a pullup the rule forbids.
- **Mixed-direction reads.** Data reads are taken with mixed directions while the pads toggle. A wrong per-bit select would echo the latch on inputs or the pad on outputs. A wrong synchronizer depth would shift the pad value by a cycle, both in the read data and in tmr_cap.
- **Unused offsets and back-to-back access.** Writes to unused offsets are followed by reads of every register, to catch a decoder that aliases high offsets onto low ones. Writes and reads on consecutive cycles check that read data belongs to the previous address and shows pre-write contents.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int OFS_DATA = 0;
  localparam int OFS_PULL = 1;
  localparam int OFS_SLEW = 2;
  localparam int OFS_DIR  = 3;

  typedef enum logic [1:0] {
    ROLE_GPIO_IN  = 2'd0,
    ROLE_GPIO_OUT = 2'd1,
    ROLE_TMR_OC   = 2'd2,
    ROLE_TMR_IC   = 2'd3
  } pin_role_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
    logic slew;
  } pad_ctl_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   pin_sync,
  output logic [NPIN-1:0]   data_q,
  output logic [NPIN-1:0]   pull_q,
  output logic [NPIN-1:0]   slew_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(OFS_PULL);
  localparam logic [ADDR_W-1:0] A_SLEW = ADDR_W'(OFS_SLEW);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

  logic wr_data, wr_pull, wr_slew, wr_dir;
  logic [NPIN-1:0] data_view;
  logic [NPIN-1:0] rd_next;

  assign wr_data = we && (addr == A_DATA);
  assign wr_pull = we && (addr == A_PULL);
  assign wr_slew = we && (addr == A_SLEW);
  assign wr_dir  = we && (addr == A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pull_q <= '0;
      slew_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_pull) pull_q <= wdata;
      if (wr_slew) slew_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  genvar b;
  generate
    for (b = 0; b < NPIN; b++) begin : g_view
      assign data_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
    end
  endgenerate

  always_comb begin
    unique case (addr)
      A_DATA:  rd_next = data_view;
      A_PULL:  rd_next = pull_q;
      A_SLEW:  rd_next = slew_q;
      A_DIR:   rd_next = dir_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0] data_q,
  input  logic [NPIN-1:0] pull_q,
  input  logic [NPIN-1:0] slew_q,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] tmr_own,
  input  logic [NPIN-1:0] tmr_oc,
  input  logic [NPIN-1:0] tmr_val,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_pu,
  output logic [NPIN-1:0] pin_slew
);
  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_pin
      pin_role_e role;
      pad_ctl_t  ctl;

      always_comb begin
        if (tmr_own[i]) role = tmr_oc[i] ? ROLE_TMR_OC : ROLE_TMR_IC;
        else            role = dir_q[i]  ? ROLE_GPIO_OUT : ROLE_GPIO_IN;
      end

      always_comb begin
        ctl = '0;
        unique case (role)
          ROLE_GPIO_OUT: begin
            ctl.oe   = 1'b1;
            ctl.out  = data_q[i];
            ctl.slew = slew_q[i];
          end
          ROLE_TMR_OC: begin
            ctl.oe   = 1'b1;
            ctl.out  = tmr_val[i];
            ctl.slew = slew_q[i];
          end
          ROLE_TMR_IC: begin
            ctl.pu   = pull_q[i] & ~dir_q[i];
          end
          default: begin
            ctl.pu   = pull_q[i];
          end
        endcase
      end

      assign pin_oe[i]   = ctl.oe;
      assign pin_out[i]  = ctl.out;
      assign pin_pu[i]   = ctl.pu;
      assign pin_slew[i] = ctl.slew;
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_pu,
  output logic [NPIN-1:0]   pin_slew,
  input  logic [NPIN-1:0]   tmr_own,
  input  logic [NPIN-1:0]   tmr_oc,
  input  logic [NPIN-1:0]   tmr_val,
  output logic [NPIN-1:0]   tmr_cap
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] data_q, pull_q, slew_q, dir_q;

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_regfile #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .data_q   (data_q),
    .pull_q   (pull_q),
    .slew_q   (slew_q),
    .dir_q    (dir_q),
    .rdata    (bus_rdata)
  );

  gpio_pin_mux #(.NPIN(NPIN)) u_mux (
    .data_q   (data_q),
    .pull_q   (pull_q),
    .slew_q   (slew_q),
    .dir_q    (dir_q),
    .tmr_own  (tmr_own),
    .tmr_oc   (tmr_oc),
    .tmr_val  (tmr_val),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu),
    .pin_slew (pin_slew)
  );

  assign tmr_cap = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_pu,
  input logic [NPIN-1:0]   pin_slew,
  input logic [NPIN-1:0]   tmr_own,
  input logic [NPIN-1:0]   tmr_oc,
  input logic [NPIN-1:0]   tmr_val,
  input logic [NPIN-1:0]   tmr_cap
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  p_oc_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_own & tmr_oc & ~pin_oe) == '0) && (((pin_out ^ tmr_val) & tmr_own & tmr_oc) == '0));

  p_ic_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_own & ~tmr_oc & (pin_oe | pin_slew)) == '0));

  p_pu_off_when_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0));

  p_slew_only_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_slew & ~pin_oe) == '0));

  p_quiet_when_floating_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  p_unused_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(4)) |=> (bus_rdata == '0));

  p_cap_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2) |-> (tmr_cap == $past(pin_in, 2)));
endmodule

bind gpio_port_ctl gpio_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_pu    (pin_pu),
  .pin_slew  (pin_slew),
  .tmr_own   (tmr_own),
  .tmr_oc    (tmr_oc),
  .tmr_val   (tmr_val),
  .tmr_cap   (tmr_cap)
);

// File: tb/sim_gpio_port_ctl.sv
module sim_gpio_port_ctl;
  localparam int NPIN = 8;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [NPIN-1:0] bus_wdata = '0;
  logic [NPIN-1:0] bus_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe, pin_pu, pin_slew, tmr_cap;
  logic [NPIN-1:0] tmr_own = '0, tmr_oc = '0, tmr_val = '0;

  always #2 clk = ~clk;

  gpio_port_ctl #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_slew(pin_slew),
    .tmr_own(tmr_own), .tmr_oc(tmr_oc), .tmr_val(tmr_val), .tmr_cap(tmr_cap)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference: register contents, two-stage pad history, read reply
  logic [7:0] m_data, m_pull, m_slew, m_dir, m_h1, m_h2, m_rd;
  int m_raddr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= 0; m_pull <= 0; m_slew <= 0; m_dir <= 0;
      m_h1 <= 0; m_h2 <= 0; m_rd <= 0; m_raddr <= 0;
    end else begin
      m_h1 <= pin_in;
      m_h2 <= m_h1;
      m_raddr <= int'(bus_addr);
      if (bus_addr == 0)      m_rd <= (m_data & m_dir) | (m_h2 & ~m_dir);
      else if (bus_addr == 1) m_rd <= m_pull;
      else if (bus_addr == 2) m_rd <= m_slew;
      else if (bus_addr == 3) m_rd <= m_dir;
      else                    m_rd <= 0;
      if (bus_we) begin
        if (bus_addr == 0) m_data <= bus_wdata;
        if (bus_addr == 1) m_pull <= bus_wdata;
        if (bus_addr == 2) m_slew <= bus_wdata;
        if (bus_addr == 3) m_dir  <= bus_wdata;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string rtag;
    rtag = (m_raddr == 0) ? "R3 data read" : (m_raddr < 4) ? "R2 register read" : "R10 unused read";
    chk(rtag, int'(bus_rdata), int'(m_rd));
    chk("R4 capture level", int'(tmr_cap), int'(m_h2));
    for (int i = 0; i < NPIN; i++) begin
      bit e_oe, e_out, e_pu, e_sl;
      string t_drv, t_pu, t_sl;
      if (tmr_own[i] && tmr_oc[i]) begin
        e_oe = 1; e_out = tmr_val[i]; e_pu = 0; e_sl = m_slew[i];
        t_drv = "R8 oc drive"; t_pu = "R8 oc pullup"; t_sl = "R8 oc slew";
      end else if (tmr_own[i]) begin
        e_oe = 0; e_out = 0; e_pu = m_pull[i] & ~m_dir[i]; e_sl = 0;
        t_drv = "R9 ic float"; t_pu = "R9 ic pullup"; t_sl = "R9 ic slew";
      end else begin
        e_oe = m_dir[i]; e_out = m_dir[i] & m_data[i];
        e_pu = m_pull[i] & ~m_dir[i]; e_sl = m_slew[i] & m_dir[i];
        t_drv = "R5 gpio drive"; t_pu = "R6 gpio pullup"; t_sl = "R7 gpio slew";
      end
      chk(t_drv, {pin_oe[i], pin_out[i]}, {e_oe, e_out});
      chk(t_pu, pin_pu[i], e_pu);
      chk(t_sl, pin_slew[i], e_sl);
    end
  endtask

  task automatic step(input int a, input bit we, input int wd);
    @(negedge clk);
    compare_all();
    bus_addr = ADDR_W'(a);
    bus_we = we;
    bus_wdata = NPIN'(wd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset oe", int'(pin_oe), 0);
    chk("R1 reset pullup", int'(pin_pu), 0);
    chk("R1 reset slew", int'(pin_slew), 0);
    chk("R1 reset rdata", int'(bus_rdata), 0);
    for (int a = 1; a < 4; a++) step(a, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);

    // R2/R3: configure, mixed directions, back-to-back writes then reads
    step(3, 1, 8'h0F);
    step(0, 1, 8'hA5);
    step(1, 1, 8'hF1);
    step(2, 1, 8'h33);
    pin_in = 8'h3C;
    for (int a = 0; a < 4; a++) step(a, 0, 0);
    // R4: toggle pad while reading data
    for (int k = 0; k < 6; k++) begin
      pin_in = pin_in ^ 8'hFF;
      step(0, 0, 0);
    end

    // R8/R9: timer ownership with direction bits set on capture pins
    step(3, 1, 8'h4F);
    tmr_own = 8'hF3; tmr_oc = 8'h31; tmr_val = 8'h12;
    for (int k = 0; k < 4; k++) step(0, 0, 0);
    tmr_val = 8'hED;
    step(1, 0, 0);
    step(2, 0, 0);

    // R10: writes to unused offsets, then read everything back
    step(5, 1, 8'hFF);
    step(7, 1, 8'h00);
    step(4, 1, 8'h81);
    for (int a = 0; a < 8; a++) step(a, 0, 0);

    tmr_own = 0;
    for (int k = 0; k < 3000; k++) begin
      pin_in  = NPIN'($urandom);
      tmr_own = NPIN'($urandom);
      tmr_oc  = NPIN'($urandom);
      tmr_val = NPIN'($urandom);
      step(int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
    end
    step(0, 0, 0);
    finish_run();
  end
endmodule